// File: doc/BRIEF.md
# Ping-Pong Input Gamma Lookup Table

This block maps each colour channel of an incoming pixel through a 256-entry lookup table. Storage is split into two complete banks, A and B, each holding one table for red, green and blue. Pixels are always translated through the bank that is in use. Software can meanwhile rebuild the other bank, and then hand it over to the pixel path at the next frame boundary.

Loading uses one data port. Software sets a start index and then writes words in groups of three: red, then green, then blue. The index moves on by one only after the blue word. A three-bit mask can drop the write for any channel, and a select bit chooses which bank receives the words. A requested mode picks bypass, bank A or bank B. The request is only applied on a frame-start strobe. At that point a status code starts showing which bank the pixel path reads. A write aimed at the bank in use is discarded and sets a sticky error flag.

Top module: `gamma_lut_pingpong`

## Requirements
- R1: Each bank holds 256 entries of 12 bits per channel, all of which can be stored and read back. The table index is the upper 8 bits of the IN_W-bit input channel value; lower bits are ignored.
- R2: Each data write fills the current entry of one channel, in the order red, green, blue. The write index increments after the blue word and wraps from 255 to 0.
- R3: An index-load strobe sets the write index to the given value and restarts the colour order at red. A pending partial entry is abandoned.
- R4: Write mask bit 0 enables red, bit 1 green and bit 2 blue. A word whose channel bit is 0 is not stored, but it still uses up its slot in the colour order.
- R5: Bank select 0 sends writes to bank A and 1 sends them to bank B. Writing the bank that is not in use leaves the pixel results unchanged.
- R6: Mode code 2 reads bank A and 3 reads bank B. Codes 0 and 1 bypass the table: the output is the 8-bit index followed by four zero bits.
- R7: The requested mode takes effect only at a clock edge where frame_start is high. The bank status changes at that same edge: 0 for bypass, 1 for bank A, 2 for bank B.
- R8: A data write whose target bank is the bank in use stores nothing and sets wr_err. The word still uses up its slot in the colour order. wr_err stays set until reset.
- R9: A pixel presented with pix_valid appears on the outputs one clock later, with out_valid high.
- R10: After reset the block is in bypass with status 0, wr_err is 0 and out_valid is 0. The write index is 0 and the next word is red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lut_idx_set | input | 1 | Load the write index and restart at red |
| lut_idx_val | input | IDX_W | Start index for loading |
| lut_wr | input | 1 | Data word strobe |
| lut_wdata | input | ENTRY_W | Entry value, unsigned 0.12 fraction |
| lut_bank_sel | input | 1 | Load target: 0 bank A, 1 bank B |
| lut_wmask | input | 3 | Per-channel write enable, bit 0 red |
| mode_req | input | 2 | Requested mode: 0/1 bypass, 2 bank A, 3 bank B |
| frame_start | input | 1 | Strobe that applies mode_req |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | IN_W | Red input |
| pix_g | input | IN_W | Green input |
| pix_b | input | IN_W | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | ENTRY_W | Red result |
| out_g | output | ENTRY_W | Green result |
| out_b | output | ENTRY_W | Blue result |
| bank_status | output | 2 | Bank in use: 0 bypass, 1 A, 2 B |
| wr_err | output | 1 | Sticky error for a write to the bank in use |

## Verification
The bench builds the block with IN_W = 10, IDX_W = 8 and ENTRY_W = 12. Ten-bit inputs carry nonzero low bits, so truncation down to the 8-bit index is exercised on every lookup. A full 256-entry depth means the index wrap from 255 to 0 can be reached, and every entry of both banks is swept through the pixel path. With a 12-bit entry, the bypass result carries four zero fill bits, which is enough to show that it is left-justified.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    localparam int NUM_CH = 3;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } ch_phase_e;

    localparam logic [1:0] MODE_BANK_A = 2'd2;
    localparam logic [1:0] MODE_BANK_B = 2'd3;

    localparam logic [1:0] STAT_BYPASS = 2'd0;
    localparam logic [1:0] STAT_BANK_A = 2'd1;
    localparam logic [1:0] STAT_BANK_B = 2'd2;

endpackage

// File: rtl/gamma_lut_wr_seq.sv
module gamma_lut_wr_seq
    import gamma_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_set,
    input  logic [IDX_W-1:0]  idx_val,
    input  logic              wr_stb,
    input  logic              bank_sel,
    input  logic [NUM_CH-1:0] wmask,
    input  logic              rd_bypass,
    input  logic              rd_bank,
    output logic [NUM_CH-1:0] ch_we,
    output logic [IDX_W-1:0]  wr_addr,
    output logic              wr_err
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        ch_phase_e        phase;
        logic             err;
    } seq_t;

    seq_t              s_d, s_q;
    logic              hit_active;
    logic [NUM_CH-1:0] phase_oh;

    always_comb begin
        s_d        = s_q;
        hit_active = !rd_bypass && (rd_bank == bank_sel);
        case (s_q.phase)
            PH_RED:  phase_oh = 3'b001;
            PH_GRN:  phase_oh = 3'b010;
            default: phase_oh = 3'b100;
        endcase
        ch_we = '0;
        if (idx_set) begin
            s_d.idx   = idx_val;
            s_d.phase = PH_RED;
        end else if (wr_stb) begin
            if (hit_active) begin
                s_d.err = 1'b1;
            end else begin
                ch_we = phase_oh & wmask;
            end
            case (s_q.phase)
                PH_RED:  s_d.phase = PH_GRN;
                PH_GRN:  s_d.phase = PH_BLU;
                default: begin
                    s_d.phase = PH_RED;
                    s_d.idx   = s_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{idx: '0, phase: PH_RED, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_addr = s_q.idx;
    assign wr_err  = s_q.err;

    // R8: the error flag never clears once set
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    // R2: the index advances after the blue word
    a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !idx_set && s_q.phase == PH_BLU) |=> (wr_addr == $past(wr_addr) + 1'b1));

    // R3: index load takes the supplied value
    a_r3_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_set |=> (wr_addr == $past(idx_val)));

endmodule

// File: rtl/gamma_lut_mode_ctl.sv
module gamma_lut_mode_ctl
    import gamma_lut_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] mode_req,
    output logic       rd_bypass,
    output logic       rd_bank,
    output logic [1:0] bank_status
);

    typedef struct packed {
        logic bypass;
        logic bank;
    } act_t;

    act_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (frame_start) begin
            case (mode_req)
                MODE_BANK_A: act_d = '{bypass: 1'b0, bank: 1'b0};
                MODE_BANK_B: act_d = '{bypass: 1'b0, bank: 1'b1};
                default:     act_d = '{bypass: 1'b1, bank: 1'b0};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '{bypass: 1'b1, bank: 1'b0};
        end else begin
            act_q <= act_d;
        end
    end

    assign rd_bypass   = act_q.bypass;
    assign rd_bank     = act_q.bank;
    assign bank_status = act_q.bypass ? STAT_BYPASS :
                         (act_q.bank ? STAT_BANK_B : STAT_BANK_A);

    // R7: no status change without a frame-start strobe
    a_r7_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(bank_status));

    // R7: bank B request reports status 2 after the strobe
    a_r7_status_b: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && mode_req == MODE_BANK_B) |=> (bank_status == STAT_BANK_B));

    // R6: codes 0 and 1 select bypass
    a_r6_bypass_code: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !mode_req[1]) |=> (bank_status == STAT_BYPASS));

endmodule

// File: rtl/gamma_lut_chan.sv
module gamma_lut_chan #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 12
) (
    input  logic               clk,
    input  logic               we,
    input  logic               wr_bank,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               rd_bank,
    input  logic [IDX_W-1:0]   rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] bank_a [DEPTH];
    logic [ENTRY_W-1:0] bank_b [DEPTH];

    always_ff @(posedge clk) begin
        if (we && !wr_bank) begin
            bank_a[wr_addr] <= wr_data;
        end
        if (we && wr_bank) begin
            bank_b[wr_addr] <= wr_data;
        end
    end

    assign rd_data = rd_bank ? bank_b[rd_addr] : bank_a[rd_addr];

endmodule

// File: rtl/gamma_lut_pingpong.sv
module gamma_lut_pingpong
    import gamma_lut_pkg::*;
#(
    parameter int IN_W    = 10,
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lut_idx_set,
    input  logic [IDX_W-1:0]   lut_idx_val,
    input  logic               lut_wr,
    input  logic [ENTRY_W-1:0] lut_wdata,
    input  logic               lut_bank_sel,
    input  logic [2:0]         lut_wmask,
    input  logic [1:0]         mode_req,
    input  logic               frame_start,
    input  logic               pix_valid,
    input  logic [IN_W-1:0]    pix_r,
    input  logic [IN_W-1:0]    pix_g,
    input  logic [IN_W-1:0]    pix_b,
    output logic               out_valid,
    output logic [ENTRY_W-1:0] out_r,
    output logic [ENTRY_W-1:0] out_g,
    output logic [ENTRY_W-1:0] out_b,
    output logic [1:0]         bank_status,
    output logic               wr_err
);

    localparam int SHIFT = IN_W - IDX_W;
    localparam int PAD_W = ENTRY_W - IDX_W;

    typedef struct packed {
        logic                           vld;
        logic [NUM_CH-1:0][ENTRY_W-1:0] px;
    } out_t;

    logic               rd_bypass;
    logic               rd_bank;
    logic [NUM_CH-1:0]  ch_we;
    logic [IDX_W-1:0]   wr_addr;
    logic [IN_W-1:0]    pix_in   [NUM_CH];
    logic [IDX_W-1:0]   rd_idx   [NUM_CH];
    logic [ENTRY_W-1:0] rd_val   [NUM_CH];
    logic [ENTRY_W-1:0] chan_res [NUM_CH];
    out_t               out_d, out_q;

    assign pix_in[0] = pix_r;
    assign pix_in[1] = pix_g;
    assign pix_in[2] = pix_b;

    gamma_lut_mode_ctl i_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .mode_req    (mode_req),
        .rd_bypass   (rd_bypass),
        .rd_bank     (rd_bank),
        .bank_status (bank_status)
    );

    gamma_lut_wr_seq #(.IDX_W(IDX_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_set   (lut_idx_set),
        .idx_val   (lut_idx_val),
        .wr_stb    (lut_wr),
        .bank_sel  (lut_bank_sel),
        .wmask     (lut_wmask),
        .rd_bypass (rd_bypass),
        .rd_bank   (rd_bank),
        .ch_we     (ch_we),
        .wr_addr   (wr_addr),
        .wr_err    (wr_err)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign rd_idx[g] = IDX_W'(pix_in[g] >> SHIFT);

        gamma_lut_chan #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) i_chan (
            .clk     (clk),
            .we      (ch_we[g]),
            .wr_bank (lut_bank_sel),
            .wr_addr (wr_addr),
            .wr_data (lut_wdata),
            .rd_bank (rd_bank),
            .rd_addr (rd_idx[g]),
            .rd_data (rd_val[g])
        );

        assign chan_res[g] = rd_bypass ? {rd_idx[g], {PAD_W{1'b0}}} : rd_val[g];
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = pix_valid;
        if (pix_valid) begin
            for (int c = 0; c < NUM_CH; c++) begin
                out_d.px[c] = chan_res[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign out_r     = out_q.px[0];
    assign out_g     = out_q.px[1];
    assign out_b     = out_q.px[2];

    // R8: storage never written in the bank the pixel path reads
    a_r8_no_active_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_we) |-> (rd_bypass || (rd_bank != lut_bank_sel)));

    // R4: a masked channel never receives a write
    a_r4_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_we & ~lut_wmask) == '0);

    // R9: output valid follows input valid by one cycle
    a_r9_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

endmodule

// File: tb/test_gamma_lut_pingpong.sv
`timescale 1ns/1ps
module test_gamma_lut_pingpong;

    localparam int IN_W    = 10;
    localparam int IDX_W   = 8;
    localparam int ENTRY_W = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               lut_idx_set = 1'b0;
    logic [IDX_W-1:0]   lut_idx_val = '0;
    logic               lut_wr = 1'b0;
    logic [ENTRY_W-1:0] lut_wdata = '0;
    logic               lut_bank_sel = 1'b0;
    logic [2:0]         lut_wmask = 3'b111;
    logic [1:0]         mode_req = 2'd0;
    logic               frame_start = 1'b0;
    logic               pix_valid = 1'b0;
    logic [IN_W-1:0]    pix_r = '0, pix_g = '0, pix_b = '0;
    logic               out_valid;
    logic [ENTRY_W-1:0] out_r, out_g, out_b;
    logic [1:0]         bank_status;
    logic               wr_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model
    int m_lut [2][3][256];
    int m_idx   = 0;
    int m_phase = 0;
    int m_act   = 0;   // 0 bypass, 1 A, 2 B
    int m_err   = 0;

    always #4 clk = ~clk;

    gamma_lut_pingpong #(.IN_W(IN_W), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) i_gamma_lut_pingpong (
        .clk(clk), .rst_n(rst_n), .lut_idx_set(lut_idx_set), .lut_idx_val(lut_idx_val),
        .lut_wr(lut_wr), .lut_wdata(lut_wdata), .lut_bank_sel(lut_bank_sel),
        .lut_wmask(lut_wmask), .mode_req(mode_req), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .bank_status(bank_status), .wr_err(wr_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int fill_val(input int bank, input int ch, input int i);
        return (i * 37 + ch * 1000 + bank * 2000 + 5) % 4096;
    endfunction

    task automatic set_index(input int v);
        lut_idx_set = 1'b1;
        lut_idx_val = IDX_W'(v);
        @(negedge clk);
        lut_idx_set = 1'b0;
        m_idx   = v;
        m_phase = 0;
    endtask

    task automatic push(input int w);
        int bank;
        bank = lut_bank_sel ? 1 : 0;
        lut_wr    = 1'b1;
        lut_wdata = ENTRY_W'(w);
        @(negedge clk);
        lut_wr = 1'b0;
        if (m_act != 0 && (m_act - 1) == bank) begin
            m_err = 1;
        end else if (lut_wmask[m_phase]) begin
            m_lut[bank][m_phase][m_idx] = w;
        end
        if (m_phase == 2) begin
            m_phase = 0;
            m_idx   = (m_idx + 1) % 256;
        end else begin
            m_phase++;
        end
    endtask

    task automatic frame(input int mode);
        mode_req    = 2'(mode);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_act = (mode == 2) ? 1 : (mode == 3) ? 2 : 0;
    endtask

    function automatic int exp_out(input int ch, input int i);
        if (m_act == 0) return i * 16;
        return m_lut[m_act - 1][ch][i];
    endfunction

    // drive one pixel by table index, with nonzero low bits for truncation
    task automatic look(input int ri, input int gi, input int bi, input string req);
        pix_valid = 1'b1;
        pix_r = IN_W'(ri * 4 + 3);
        pix_g = IN_W'(gi * 4 + 1);
        pix_b = IN_W'(bi * 4 + 2);
        @(negedge clk);
        pix_valid = 1'b0;
        chk({req, " R9 valid"}, int'(out_valid), 1);
        chk({req, " red"},   int'(out_r), exp_out(0, ri));
        chk({req, " green"}, int'(out_g), exp_out(1, gi));
        chk({req, " blue"},  int'(out_b), exp_out(2, bi));
    endtask

    task automatic load_full(input int bank);
        lut_bank_sel = bank[0];
        lut_wmask    = 3'b111;
        set_index(0);
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) push(fill_val(bank, c, i));
        end
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 256; i++) look(i, 255 - i, (i * 7) % 256, req);
    endtask

    task automatic t_reset;
        chk("R10 status", int'(bank_status), 0);
        chk("R10 err", int'(wr_err), 0);
        chk("R10 valid", int'(out_valid), 0);
    endtask

    task automatic t_bypass;
        look(255, 0, 128, "R6 bypass");
        look(1, 17, 200, "R6 bypass");
        @(negedge clk);
        chk("R9 valid drops", int'(out_valid), 0);
    endtask

    task automatic t_load_a_and_select;
        load_full(0);
        chk("R5 no err on inactive load", int'(wr_err), 0);
        mode_req = 2'd2;
        repeat (3) @(negedge clk);
        chk("R7 status held without strobe", int'(bank_status), 0);
        look(9, 9, 9, "R7 still bypass");
        frame(2);
        chk("R7 status bank A", int'(bank_status), 1);
        sweep("R1 sweep bank A");
    endtask

    task automatic t_load_b_while_a;
        load_full(1);
        look(3, 100, 250, "R5 A unaffected by B load");
        chk("R5 no err", int'(wr_err), 0);
        frame(3);
        chk("R7 status bank B", int'(bank_status), 2);
        sweep("R1 sweep bank B");
    endtask

    task automatic t_mask_and_wrap;
        lut_bank_sel = 1'b0;        // A inactive now
        lut_wmask    = 3'b101;
        set_index(5);
        push(12'h111); push(12'h222); push(12'h333);
        lut_wmask = 3'b111;
        set_index(255);
        push(12'hA01); push(12'hA02); push(12'hA03);
        push(12'hB01); push(12'hB02); push(12'hB03);
        frame(2);
        look(5, 5, 5, "R4 mask 101");
        chk("R4 green kept", int'(out_g), fill_val(0, 1, 5));
        chk("R4 red stored", int'(out_r), 12'h111);
        look(255, 255, 255, "R2 entry 255");
        chk("R2 blue at 255", int'(out_b), 12'hA03);
        look(0, 0, 0, "R2 wrap to 0");
        chk("R2 red at 0", int'(out_r), 12'hB01);
    endtask

    task automatic t_index_restart;
        lut_bank_sel = 1'b1;        // B inactive now
        set_index(10);
        push(12'hC10);
        set_index(20);
        push(12'hD01); push(12'hD02); push(12'hD03);
        frame(3);
        look(10, 10, 10, "R3 partial entry");
        chk("R3 green 10 unchanged", int'(out_g), fill_val(1, 1, 10));
        look(20, 20, 20, "R3 restart at red");
        chk("R3 red 20", int'(out_r), 12'hD01);
    endtask

    task automatic t_active_write;
        lut_bank_sel = 1'b1;        // B is in use
        set_index(30);
        push(12'hEEE); push(12'hEEE); push(12'hEEE);
        chk("R8 err set", int'(wr_err), 1);
        look(30, 30, 30, "R8 active bank untouched");
        chk("R8 red 30", int'(out_r), fill_val(1, 0, 30));
        // slot consumed: next entry goes to 31 in bank A
        lut_bank_sel = 1'b0;
        push(12'h0F1); push(12'h0F2); push(12'h0F3);
        repeat (4) @(negedge clk);
        chk("R8 err sticky", int'(wr_err), 1);
        frame(2);
        look(31, 31, 31, "R8 order kept after drop");
        chk("R8 red 31 in A", int'(out_r), 12'h0F1);
        frame(1);
        chk("R6 code 1 bypass status", int'(bank_status), 0);
        look(64, 7, 200, "R6 code 1 bypass");
        chk("R10 err survives mode", int'(wr_err), m_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_bypass;
        t_load_a_and_select;
        t_load_b_while_a;
        t_mask_and_wrap;
        t_index_restart;
        t_active_write;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule